// File: doc/BRIEF.md
# Dual Timer/Counter

This block provides two independent 16-bit timer/counter channels. Each channel holds its count in a low byte and a high byte. A channel counts either a prescaled internal tick, which occurs once every twelve clocks, or falling edges on its own external count pin. An optional per-channel gate pin can hold the count. A shared configuration byte picks, for each channel, a 13-bit, 16-bit, 8-bit auto-reload or split-byte arrangement.

Software reaches every register through a small synchronous address/data bus. Reads are combinational and writes take effect on the clock edge. Each channel raises a sticky overflow flag. The second channel also drives a one-cycle overflow pulse, which a serial port can use as its baud source.

Top module: `tmr_pair`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every register reads 0, both overflow flags are 0 and `baud_tick` is 0. Register addresses are: 0 configuration, 1 control, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high. Addresses 6 and 7 read 0.
- R2: In timer mode (configuration bit 2 of the channel nibble = 0), a running channel advances by one on each internal tick. The tick fires when a free-running modulo-12 counter, cleared by reset, reaches 11.
- R3: In counter mode (nibble bit 2 = 1), the channel advances once for each 1-to-0 transition of its `ext_in` bit. Each transition is seen through a two-flop synchroniser plus one more sample, so the count changes three edges after the pin falls.
- R4: With gate-enable set (nibble bit 3 = 1), a channel advances only while its `gate_in` bit, delayed through two flops, is 1.
- R5: In mode 1 (nibble bits 1:0 = 1), the channel is a 16-bit counter. Stepping from FFFF to 0000 sets the channel's overflow flag.
- R6: In mode 0, only bits 4:0 of the low byte count, and their carry advances the high byte. Low bits 7:5 keep their value. Overflow occurs when the high byte is FF and low bits 4:0 are 1F.
- R7: In mode 2, the low byte counts. On stepping from FF it reloads from the high byte and flags overflow. The high byte changes only when written.
- R8: In mode 3 on channel 0, the low byte is an 8-bit counter under channel 0's controls and sets flag 0. The high byte counts internal ticks while the channel 1 run bit is set, and its overflow sets flag 1 in place of channel 1. Channel 1 in mode 3 holds its count.
- R9: Control register bit 4 is flag 0 and bit 5 is flag 1. A control write loads both flags from the written bits. An overflow in the same cycle sets its flag regardless of the write. Flags are otherwise sticky.
- R10: `baud_tick` is high for exactly one cycle, one cycle after each channel 1 wrap.
- R11: A write to either byte of a channel loads that byte. That channel does not count in the same cycle.
- R12: Control bits 0 and 1 are the run bits of channels 0 and 1. A channel whose run bit is 0 keeps its low byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_in | input | 2 | External count pins, bit n for channel n |
| gate_in | input | 2 | Gate pins, bit n for channel n |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `addr` |
| ovf_flag | output | 2 | Sticky overflow flags |
| baud_tick | output | 1 | One-cycle pulse per channel 1 wrap |

## Verification
The assertions assume that `ext_in` cannot produce two falling edges on consecutive cycles. This holds for any real pin, because a fall needs a high sample first, so channel 1 wraps can never be adjacent. They also assume that the bus never writes a channel's bytes while expecting that channel to keep counting. The stimulus holds each external pin level for at least two cycles, so every edge passes the synchroniser cleanly. It changes gate pins only between pulse trains and performs writes as isolated single-cycle strobes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int ADDR_W  = 3;
   localparam int CFG_W   = 4;
   localparam int PRE_BITS = 5;

   typedef logic [ADDR_W-1:0] tmr_addr_t;

   localparam tmr_addr_t A_CFG  = 3'd0;
   localparam tmr_addr_t A_CTRL = 3'd1;
   localparam tmr_addr_t A_LO0  = 3'd2;
   localparam tmr_addr_t A_HI0  = 3'd3;
   localparam tmr_addr_t A_LO1  = 3'd4;
   localparam tmr_addr_t A_HI1  = 3'd5;

   typedef enum logic [1:0] {
      TM_13     = 2'd0,
      TM_16     = 2'd1,
      TM_RELOAD = 2'd2,
      TM_SPLIT  = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      gate_en;
      logic      ext_sel;
      tmr_mode_e mode;
   } tmr_cfg_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk) begin
      if (rst) pipe[0] <= '0;
      else     pipe[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) pipe[s] <= '0;
         else     pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int PW = $clog2(DIV);

   logic [PW-1:0] cnt;

   assign tick = (cnt == PW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (rst || tick) cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  tmr_mode_e     mode,
   input  logic          inc,
   input  logic          hi_inc,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] lo_q,
   output logic [DW-1:0] hi_q,
   output logic          wrap,
   output logic          hwrap
);
   localparam int PB = PRE_BITS;

   logic [DW-1:0] lo_n, hi_n;

   always_comb begin
      lo_n  = lo_q;
      hi_n  = hi_q;
      wrap  = 1'b0;
      hwrap = 1'b0;
      if (wr_lo || wr_hi) begin
         if (wr_lo) lo_n = wdata;
         if (wr_hi) hi_n = wdata;
      end else begin
         case (mode)
            TM_13: if (inc) begin
               if (&lo_q[PB-1:0]) begin
                  lo_n[PB-1:0] = '0;
                  hi_n         = hi_q + 1'b1;
                  wrap         = &hi_q;
               end else begin
                  lo_n[PB-1:0] = lo_q[PB-1:0] + 1'b1;
               end
            end
            TM_16: if (inc) begin
               lo_n = lo_q + 1'b1;
               if (&lo_q) begin
                  hi_n = hi_q + 1'b1;
                  wrap = &hi_q;
               end
            end
            TM_RELOAD: if (inc) begin
               if (&lo_q) begin
                  lo_n = hi_q;
                  wrap = 1'b1;
               end else begin
                  lo_n = lo_q + 1'b1;
               end
            end
            TM_SPLIT: begin
               if (inc) begin
                  lo_n = lo_q + 1'b1;
                  wrap = &lo_q;
               end
               if (hi_inc) begin
                  hi_n  = hi_q + 1'b1;
                  hwrap = &hi_q;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int DW          = 8,
   parameter int PRESCALE    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      ext_in,
   input  logic [1:0]      gate_in,
   input  logic [ADDR_W-1:0] addr,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_data,
   output logic [DW-1:0]   rd_data,
   output logic [1:0]      ovf_flag,
   output logic            baud_tick
);
   localparam int NCH   = 2;
   localparam int CFG_T = NCH * CFG_W;

   if (DW != CFG_T) begin : g_bad_dw
      $error("tmr_pair: DW must equal the configuration width");
   end
   if (PRESCALE < 2) begin : g_bad_pre
      $error("tmr_pair: PRESCALE must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("tmr_pair: SYNC_STAGES must be at least 1");
   end

   logic [CFG_T-1:0]      mode_q;
   logic [NCH-1:0]        run_q;
   logic [NCH-1:0]        flag_q, flag_n;
   logic                  baud_q;
   logic [NCH-1:0]        ext_s, gate_s, ext_prev, fall;
   logic                  tick;
   tmr_cfg_t              cfg [NCH];
   logic [NCH-1:0]        inc, hi_inc, wr_lo, wr_hi, wrap, hwrap;
   logic [NCH-1:0][DW-1:0] ch_lo, ch_hi;
   logic                  wr_ctrl;

   tmr_sync #(.W(2*NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({gate_in, ext_in}),
      .q   ({gate_s, ext_s})
   );

   tmr_prescale #(.DIV(PRESCALE)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   assign fall    = ext_prev & ~ext_s;
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_lo   = {wr_en && (addr == A_LO1), wr_en && (addr == A_LO0)};
   assign wr_hi   = {wr_en && (addr == A_HI1), wr_en && (addr == A_HI0)};

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         cfg[c] = tmr_cfg_t'(mode_q[c*CFG_W +: CFG_W]);
         inc[c] = run_q[c] && (!cfg[c].gate_en || gate_s[c]) &&
                  (cfg[c].ext_sel ? fall[c] : tick);
      end
      if (cfg[1].mode == TM_SPLIT) inc[1] = 1'b0;
      hi_inc[0] = tick && run_q[1] && (cfg[0].mode == TM_SPLIT);
      hi_inc[1] = 1'b0;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      tmr_chan #(.DW(DW)) u_ch (
         .clk    (clk),
         .rst    (rst),
         .mode   (cfg[c].mode),
         .inc    (inc[c]),
         .hi_inc (hi_inc[c]),
         .wr_lo  (wr_lo[c]),
         .wr_hi  (wr_hi[c]),
         .wdata  (wr_data),
         .lo_q   (ch_lo[c]),
         .hi_q   (ch_hi[c]),
         .wrap   (wrap[c]),
         .hwrap  (hwrap[c])
      );
   end

   always_comb begin
      flag_n = wr_ctrl ? wr_data[5:4] : flag_q;
      flag_n[0] = flag_n[0] | wrap[0];
      flag_n[1] = flag_n[1] |
                  ((cfg[0].mode == TM_SPLIT) ? hwrap[0] : (wrap[1] | hwrap[1]));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q   <= '0;
         run_q    <= '0;
         flag_q   <= '0;
         baud_q   <= 1'b0;
         ext_prev <= '0;
      end else begin
         if (wr_en && (addr == A_CFG)) mode_q <= wr_data;
         if (wr_ctrl)                  run_q  <= wr_data[1:0];
         flag_q   <= flag_n;
         baud_q   <= wrap[1];
         ext_prev <= ext_s;
      end
   end

   always_comb begin
      case (addr)
         A_CFG:   rd_data = mode_q;
         A_CTRL:  rd_data = {2'b00, flag_q, 2'b00, run_q};
         A_LO0:   rd_data = ch_lo[0];
         A_HI0:   rd_data = ch_hi[0];
         A_LO1:   rd_data = ch_lo[1];
         A_HI1:   rd_data = ch_hi[1];
         default: rd_data = '0;
      endcase
   end

   assign ovf_flag  = flag_q;
   assign baud_tick = baud_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
   import tmr_pkg::*;
#(
   parameter int DW = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        ovf_flag,
   input logic              baud_tick,
   input logic [1:0]        run_q,
   input logic [7:0]        mode_q,
   input logic [DW-1:0]     lo0,
   input logic [DW-1:0]     hi1
);
   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (ovf_flag == 2'b00 && !baud_tick)); // R1

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag[0] && !(wr_en && addr == A_CTRL)) |=> ovf_flag[0]); // R9

   AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      baud_tick |=> !baud_tick); // R10

   AST_RELOAD_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_q[5:4] == 2'd2 && !(wr_en && addr == A_HI1)) |=> $stable(hi1)); // R7

   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!run_q[0] && !(wr_en && addr == A_LO0)) |=> $stable(lo0)); // R12
endmodule

bind tmr_pair tmr_pair_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .addr      (addr),
   .ovf_flag  (ovf_flag),
   .baud_tick (baud_tick),
   .run_q     (run_q),
   .mode_q    (mode_q),
   .lo0       (ch_lo[0]),
   .hi1       (ch_hi[1])
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] ext_in = 2'b00;
   logic [1:0] gate_in = 2'b00;
   logic [2:0] addr = 3'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic [1:0] ovf_flag;
   logic       baud_tick;

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 0;
   string phase = "R1";

   always #10 clk = ~clk;

   tmr_pair u0 (
      .clk(clk), .rst(rst), .ext_in(ext_in), .gate_in(gate_in),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .ovf_flag(ovf_flag), .baud_tick(baud_tick)
   );

   // behavioural reference model
   int       m_pc;
   bit [7:0] m_mode;
   bit [1:0] m_run, m_flag;
   bit [7:0] m_lo [2];
   bit [7:0] m_hi [2];
   bit [1:0] m_s1, m_s2, m_s3, m_g1, m_g2;
   bit       m_baud;

   function automatic void chan_step(int c, bit en, bit hen, bit wl, bit wh,
                                     bit [7:0] wd, output bit w, output bit hw);
      w = 0; hw = 0;
      if (wl || wh) begin
         if (wl) m_lo[c] = wd;
         if (wh) m_hi[c] = wd;
         return;
      end
      case (m_mode[4*c +: 2])
         2'd0: if (en) begin
            if ((m_lo[c] & 8'h1f) == 8'h1f) begin
               m_lo[c] = m_lo[c] & 8'he0;
               if (m_hi[c] == 8'hff) w = 1;
               m_hi[c] = m_hi[c] + 8'd1;
            end else m_lo[c] = m_lo[c] + 8'd1;
         end
         2'd1: if (en) begin
            if (m_lo[c] == 8'hff) begin
               if (m_hi[c] == 8'hff) w = 1;
               m_hi[c] = m_hi[c] + 8'd1;
            end
            m_lo[c] = m_lo[c] + 8'd1;
         end
         2'd2: if (en) begin
            if (m_lo[c] == 8'hff) begin m_lo[c] = m_hi[c]; w = 1; end
            else m_lo[c] = m_lo[c] + 8'd1;
         end
         default: begin
            if (en) begin
               if (m_lo[c] == 8'hff) w = 1;
               m_lo[c] = m_lo[c] + 8'd1;
            end
            if (hen) begin
               if (m_hi[c] == 8'hff) hw = 1;
               m_hi[c] = m_hi[c] + 8'd1;
            end
         end
      endcase
   endfunction

   always @(posedge clk) begin
      bit tk;
      bit [1:0] en, w, hw;
      bit hen;
      if (rst) begin
         m_pc = 0; m_mode = 0; m_run = 0; m_flag = 0; m_baud = 0;
         m_lo[0] = 0; m_lo[1] = 0; m_hi[0] = 0; m_hi[1] = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_g1 = 0; m_g2 = 0;
      end else begin
         tk = (m_pc == 11);
         for (int c = 0; c < 2; c++)
            en[c] = m_run[c] && (!m_mode[4*c+3] || m_g2[c]) &&
                    (m_mode[4*c+2] ? (m_s3[c] && !m_s2[c]) : tk);
         if (m_mode[5:4] == 2'd3) en[1] = 0;
         hen = tk && m_run[1] && (m_mode[1:0] == 2'd3);
         chan_step(0, en[0], hen, wr_en && addr == 3'd2, wr_en && addr == 3'd3,
                   wr_data, w[0], hw[0]);
         chan_step(1, en[1], 1'b0, wr_en && addr == 3'd4, wr_en && addr == 3'd5,
                   wr_data, w[1], hw[1]);
         if (wr_en && addr == 3'd1) m_flag = wr_data[5:4];
         m_flag[0] = m_flag[0] | w[0];
         m_flag[1] = m_flag[1] | ((m_mode[1:0] == 2'd3) ? hw[0] : w[1]);
         m_baud = w[1];
         if (wr_en && addr == 3'd0) m_mode = wr_data;
         if (wr_en && addr == 3'd1) m_run = wr_data[1:0];
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
         m_g2 = m_g1; m_g1 = gate_in;
         m_pc = tk ? 0 : m_pc + 1;
      end
   end

   function automatic bit [7:0] model_rd(bit [2:0] a);
      case (a)
         3'd0: return m_mode;
         3'd1: return {2'b00, m_flag, 2'b00, m_run};
         3'd2: return m_lo[0];
         3'd3: return m_hi[0];
         3'd4: return m_lo[1];
         3'd5: return m_hi[1];
         default: return 8'h00;
      endcase
   endfunction

   task automatic cyc();
      bit [7:0] er;
      @(negedge clk);
      er = model_rd(addr);
      vectors++;
      if (rd_data !== er || baud_tick !== m_baud || ovf_flag !== m_flag) begin
         miscompares++;
         $display("FAIL %s addr=%0d: rd=%h exp %h, baud=%b exp %b, flag=%b exp %b",
                  phase, addr, rd_data, er, baud_tick, m_baud, ovf_flag, m_flag);
      end
   endtask

   int rot = 0;
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         wr_en = 0;
         addr = 3'(rot);
         rot++;
         cyc();
      end
   endtask

   task automatic wr(bit [2:0] a, bit [7:0] d);
      addr = a; wr_data = d; wr_en = 1;
      cyc();
      wr_en = 0;
   endtask

   task automatic pulse(int c, int n);
      for (int i = 0; i < n; i++) begin
         ext_in[c] = 1; idle(2);
         ext_in[c] = 0; idle(2);
      end
   endtask

   initial begin
      phase = "R1";
      idle(3);
      rst = 0;
      idle(10);

      phase = "R2";
      wr(3'd0, 8'h11);
      wr(3'd1, 8'h01);
      idle(60);

      phase = "R11";
      wr(3'd2, 8'hfe);
      idle(30);

      phase = "R5";
      wr(3'd3, 8'hff);
      wr(3'd2, 8'hfd);
      idle(60);

      phase = "R9";
      wr(3'd1, 8'h01);
      idle(8);
      wr(3'd1, 8'h21);
      idle(4);
      wr(3'd1, 8'h01);
      idle(4);

      phase = "R6";
      wr(3'd0, 8'h10);
      wr(3'd2, 8'hbd);
      wr(3'd3, 8'hff);
      idle(60);

      phase = "R3";
      wr(3'd1, 8'h02);
      wr(3'd0, 8'h50);
      pulse(1, 6);
      pulse(0, 3);
      idle(6);

      phase = "R4";
      gate_in[1] = 0;
      wr(3'd0, 8'hd0);
      idle(4);
      pulse(1, 4);
      gate_in[1] = 1;
      idle(4);
      pulse(1, 4);

      phase = "R7 R10";
      wr(3'd0, 8'h60);
      wr(3'd5, 8'hfc);
      wr(3'd4, 8'hfe);
      pulse(1, 12);
      idle(4);

      phase = "R8";
      wr(3'd1, 8'h00);
      wr(3'd0, 8'h33);
      wr(3'd2, 8'hfa);
      wr(3'd3, 8'hfc);
      wr(3'd1, 8'h03);
      idle(120);

      phase = "R12";
      wr(3'd1, 8'h00);
      idle(40);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule